// File: doc/BRIEF.md
# Two-Stage Serial Baud Enable Generator

This block turns the internal bus clock into the two timing strobes a serial port needs. The first stage is a prescaler that divides by 1, 3, 4 or 13 and sets the fastest rate available. The second stage divides that result by a power of two from 1 to 128. The output of this second stage is the 16x oversampling strobe for the receiver. A fixed divide-by-16 after it gives the 1x bit strobe for the transmitter.

Both strobes are single-cycle enables in the bus clock domain. Each stage advances only when the stage before it pulses, so the block creates no derived clock. The two select fields are loaded through a one-cycle write strobe. The same write restarts every counter, so a new rate applies at once and no stale count is carried over.

A reset clears the prescaler selection. The power-of-two selection is not touched by reset and keeps its last written value, which is zero at power-up.

Top module: `baud_chain`

## Requirements
- R1: The prescaler field `cfg_pre_i` decodes as 0 → divide by 1, 1 → divide by 3, 2 → divide by 4, 3 → divide by 13.
- R2: The rate field `cfg_rate_i` holds a value N from 0 to 7 and further divides the prescaler output by 2^N.
- R3: `rx_tick_o` is high for exactly one cycle in every P cycles, where P = prescale × 2^N. Counting the first cycle after a restart as cycle 0, the first pulse falls in cycle P−1.
- R4: When both fields are zero, `rx_tick_o` is high on every cycle.
- R5: `tx_tick_o` is high on every 16th `rx_tick_o` pulse and only on those, giving a period of 16·P with the first pulse in cycle 16·P−1.
- R6: A cycle with `cfg_we_i` high loads both fields and clears every counter at the same edge. The next cycle is cycle 0 of the new rate, and this holds even when the write comes in the middle of a count.
- R7: An active-low asynchronous reset sets the prescaler field to 0 and clears all counters. The rate field keeps its value through reset. During and after reset, timing follows R3 and R5 with the retained N.
- R8: `tx_tick_o` is never high unless `rx_tick_o` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for both select fields |
| cfg_pre_i | input | 2 | Prescaler select |
| cfg_rate_i | input | 3 | Power-of-two rate select N |
| rx_tick_o | output | 1 | 16x receiver sampling enable |
| tx_tick_o | output | 1 | 1x transmit bit enable |

## Verification
A wrong prescaler or rate count moves `rx_tick_o`, and the error shows at the first expected pulse, no later than P cycles after a restart. A fault in the divide-by-16 stage may leave the receive strobe correct but move `tx_tick_o`, so it can take up to 16·P cycles to appear. For that reason every one of the 32 field combinations runs for at least one full transmit period. A write failing to restart the counters shows as a pulse too early or too late after the write. A reset that clears the rate field shows as a change in period right after reset.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned PRE_SEL_W  = 2;
  localparam int unsigned RATE_SEL_W = 3;
  localparam int unsigned OVS_RATIO  = 16;
  localparam int unsigned PRE_CNT_W  = 4;

  typedef enum logic [PRE_SEL_W-1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV3  = 2'd1,
    PRE_DIV4  = 2'd2,
    PRE_DIV13 = 2'd3
  } pre_sel_e;

  function automatic logic [PRE_CNT_W-1:0] pre_last(pre_sel_e sel);
    case (sel)
      PRE_DIV1:  pre_last = PRE_CNT_W'(0);
      PRE_DIV3:  pre_last = PRE_CNT_W'(2);
      PRE_DIV4:  pre_last = PRE_CNT_W'(3);
      default:   pre_last = PRE_CNT_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  pre_sel_e sel_i,
  output logic     tick_o
);
  logic [PRE_CNT_W-1:0] cnt_q;
  logic [PRE_CNT_W-1:0] last;

  assign last   = pre_last(sel_i);
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_pow2_div.sv
module baud_pow2_div #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CW = (2**SEL_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  // lim = 2^sel - 1
  assign lim    = ~({CW{1'b1}} << sel_i);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_fixed_div.sv
module baud_fixed_div #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (RATIO <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt_q;

      assign tick_o = en_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else if (en_i)   cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/baud_chain.sv
module baud_chain
  import baud_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [PRE_SEL_W-1:0]  cfg_pre_i,
  input  logic [RATE_SEL_W-1:0] cfg_rate_i,
  output logic                  rx_tick_o,
  output logic                  tx_tick_o
);
  pre_sel_e              pre_q;
  logic [RATE_SEL_W-1:0] rate_q = '0;
  logic                  pre_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= PRE_DIV1;
    else if (cfg_we_i) pre_q <= pre_sel_e'(cfg_pre_i);
  end

  // rate select survives reset
  always_ff @(posedge clk_i) begin
    if (cfg_we_i) rate_q <= cfg_rate_i;
  end

  baud_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .sel_i  (pre_q),
    .tick_o (pre_tick)
  );

  baud_pow2_div #(.SEL_W(RATE_SEL_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .en_i   (pre_tick),
    .sel_i  (rate_q),
    .tick_o (rx_tick_o)
  );

  baud_fixed_div #(.RATIO(OVS_RATIO)) u_ovs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .en_i   (rx_tick_o),
    .tick_o (tx_tick_o)
  );
endmodule

// File: rtl/baud_chain_chk.sv
module baud_chain_chk
  import baud_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_we_i,
  input logic [PRE_SEL_W-1:0]  cfg_pre_i,
  input logic [RATE_SEL_W-1:0] cfg_rate_i,
  input logic                  rx_tick_o,
  input logic                  tx_tick_o,
  input pre_sel_e              pre_q,
  input logic [RATE_SEL_W-1:0] rate_q
);
  localparam int unsigned RCW = $clog2(OVS_RATIO) + 1;
  logic [RCW-1:0] rx_seen_q;

  // rx pulses since last tx or restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_seen_q <= '0;
    else if (cfg_we_i)  rx_seen_q <= '0;
    else if (tx_tick_o) rx_seen_q <= '0;
    else if (rx_tick_o) rx_seen_q <= rx_seen_q + 1'b1;
  end

  logic slow;
  assign slow = (pre_q != PRE_DIV1) || (rate_q != '0);

  assert_tx_in_rx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> rx_tick_o);

  assert_fast_every_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q == PRE_DIV1 && rate_q == '0) |-> rx_tick_o);

  assert_rx_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow && rx_tick_o && !cfg_we_i) |=> !rx_tick_o);

  assert_tx_sixteenth_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> (rx_seen_q == RCW'(OVS_RATIO - 1)));

  assert_write_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_pre_i != '0 || cfg_rate_i != '0)) |=> (!rx_tick_o && !tx_tick_o));
endmodule

bind baud_chain baud_chain_chk i_chk (.*);

// File: tb/test_baud_chain.sv
`timescale 1ns/1ps
module test_baud_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] pre = 2'd0;
  logic [2:0] rate = 3'd0;
  logic       rx_tick, tx_tick;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R7";

  // behavioural reference
  int c = 0;
  int pre_m = 0;
  int rate_m = 0;

  always #2 clk = ~clk;

  baud_chain i_baud_chain (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_pre_i  (pre),
    .cfg_rate_i (rate),
    .rx_tick_o  (rx_tick),
    .tx_tick_o  (tx_tick)
  );

  function automatic int ratio(int p);
    case (p)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic int period(int p, int r);
    return ratio(p) << r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c = 0;
      pre_m = 0;
    end else if (we) begin
      c = 0;
      pre_m = int'(pre);
      rate_m = int'(rate);
    end else begin
      c = c + 1;
    end
  end

  always @(negedge clk) begin
    int p;
    logic exp_rx, exp_tx;
    p = period(pre_m, rate_m);
    exp_rx = ((c + 1) % p) == 0;
    exp_tx = ((c + 1) % (16 * p)) == 0;
    checks++;
    if (rx_tick !== exp_rx) begin
      fails++;
      $display("FAIL %s rx_tick pre=%0d rate=%0d c=%0d actual=%b expected=%b",
               tag, pre_m, rate_m, c, rx_tick, exp_rx);
    end
    checks++;
    if (tx_tick !== exp_tx) begin
      fails++;
      $display("FAIL %s tx_tick pre=%0d rate=%0d c=%0d actual=%b expected=%b",
               tag, pre_m, rate_m, c, tx_tick, exp_tx);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<195000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int p, input int r);
    @(posedge clk); #1;
    we = 1'b1; pre = 2'(p); rate = 3'(r);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    // R7: reset state, both fields zero at power-up
    tag = "R7";
    run(3); #1;
    rst_n = 1'b1;
    tag = "R4";
    run(40);

    // R1 R2 R3 R5: every field combination
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 8; r++) begin
        int per;
        per = period(p, r);
        tag = (p == 0 && r == 0) ? "R4" : "R3 R5 (R1 R2)";
        wr(p, r);
        run(per <= 64 ? 32 * per + 3 : 16 * per + 3);
      end
    end

    // R6: write in the middle of a count
    tag = "R6";
    wr(3, 2);
    run(30);
    wr(1, 1);
    run(200);
    wr(2, 0);
    run(2);
    wr(0, 0);
    run(40);

    // R7: rate field kept through reset, prescaler cleared
    tag = "R7";
    wr(3, 3);
    run(50);
    @(posedge clk); #1;
    rst_n = 1'b0;
    run(3); #1;
    rst_n = 1'b1;
    run(16 * 8 * 2 + 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule